// File: doc/BRIEF.md
# Double-Rate Pair Transition Codec

This block lowers the switching activity of a wire that carries two logical signals at double data rate. On the transmit side it compares each new pair of signal values with the last pair it accepted. It then sends a 2-bit transition symbol instead of the raw values. The symbol says which of the two signals changed: neither, both, only the first, or only the second. Four fixed symbol tables are available. Each lane of the bus picks its own table, so a wide bus can use one code for its slowly moving high-order or sign bits and another for its busy low-order bits. A raw mode sends the pair unencoded.

On the receive side the decoder keeps its own copy of the last pair. It applies the inverse of the lane's table to rebuild the original values. Encoder and decoder share one registered per-lane code setting. A new setting is taken only on a cycle where neither side has valid data in flight, so both ends always agree on the table. Serialization onto the physical wire and its timing are handled elsewhere.

Top module: `pair_codec`

## Requirements
- R1: While reset is asserted and right after it, symValid, outValid, symData and outPair are all zero, and every lane's active mode is raw. The previous-pair history of both encoder and decoder is 00. The first valid pair is therefore encoded against 00.
- R2: Lane i carries its first signal on bit 2i+1 and its second signal on bit 2i of txPair and outPair. Its transition value is {first changed, second changed}, taken between the new pair and the last pair accepted with valid: 00 none, 11 both, 01 second only, 10 first only.
- R3: Mode value 1 maps the transitions none/both/second-only/first-only to symbols 00/11/01/10.
- R4: Mode value 2 maps none/both/second-only/first-only to 00/10/01/11.
- R5: Mode value 3 maps none/both/second-only/first-only to 01/10/00/11.
- R6: Mode value 4 maps none/both/second-only/first-only to 00/10/11/01.
- R7: Mode value 0, and the unused values 5 to 7, are raw. The symbol equals the new pair, and the decoder outputs the received symbol unchanged.
- R8: Each lane takes its mode from its own 3-bit field cfgCode[3i+2:3i]. Lanes in different modes do not affect one another.
- R9: When symData and symValid are looped back to rxSym and rxValid, outPair reproduces every valid pair one cycle after its symbol, for every mode.
- R10: symValid follows txValid one cycle later and outValid follows rxValid one cycle later. On a cycle without valid, the symbol, the decoded pair and both histories hold. An idle cycle therefore does not change how the next pair is encoded.
- R11: cfgCode becomes the active mode one cycle after a cycle on which txValid and rxValid are both low. It has no effect while either one is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgCode | input | 3*LANES | Requested mode per lane, 3 bits per lane |
| txValid | input | 1 | A new pair is presented on txPair |
| txPair | input | 2*LANES | New signal pair per lane |
| symValid | output | 1 | symData holds a fresh symbol |
| symData | output | 2*LANES | Encoded transition symbol per lane |
| rxValid | input | 1 | A received symbol is presented on rxSym |
| rxSym | input | 2*LANES | Received symbol per lane |
| outValid | output | 1 | outPair holds a freshly decoded pair |
| outPair | output | 2*LANES | Rebuilt signal pair per lane |

## Verification
The assertions check the handshake timing on every cycle: symValid tracks txValid, and symData holds on idle cycles. They also check that the active mode freezes while any data is in flight and loads the request only on fully idle cycles, and that a raw lane passes its pair straight through. The correctness of the four symbol tables, the independence of lanes in mixed modes and the lossless round trip are shown by the bench's scenarios. These use directed transitions of each class and long seeded random streams with idle gaps. The bench also reports the output toggle count for each code.

// File: rtl/pair_codec_pkg.sv
package pair_codec_pkg;

  localparam int MODE_W = 3;
  localparam int PAIR_W = 2;

  localparam logic [MODE_W-1:0] MODE_RAW = 3'd0;
  localparam logic [MODE_W-1:0] MODE_C1  = 3'd1;
  localparam logic [MODE_W-1:0] MODE_C2  = 3'd2;
  localparam logic [MODE_W-1:0] MODE_C3  = 3'd3;
  localparam logic [MODE_W-1:0] MODE_C4  = 3'd4;

  // Strobes from control to datapath
  typedef struct packed {
    logic encStep;  // encoder accepts a pair this cycle
    logic decStep;  // decoder accepts a symbol this cycle
  } strobes_t;

  function automatic logic isCoded(input logic [MODE_W-1:0] mode);
    return (mode != MODE_RAW) && (mode <= MODE_C4);
  endfunction

  // Transition value {first changed, second changed} -> symbol
  function automatic logic [PAIR_W-1:0] mapSym(input logic [MODE_W-1:0] mode,
                                               input logic [PAIR_W-1:0] chg);
    logic [PAIR_W-1:0] s;
    s = chg;
    case (mode)
      MODE_C1: s = chg;
      MODE_C2: case (chg)
                 2'b00: s = 2'b00;
                 2'b11: s = 2'b10;
                 2'b01: s = 2'b01;
                 default: s = 2'b11;
               endcase
      MODE_C3: case (chg)
                 2'b00: s = 2'b01;
                 2'b11: s = 2'b10;
                 2'b01: s = 2'b00;
                 default: s = 2'b11;
               endcase
      MODE_C4: case (chg)
                 2'b00: s = 2'b00;
                 2'b11: s = 2'b10;
                 2'b01: s = 2'b11;
                 default: s = 2'b01;
               endcase
      default: s = chg;
    endcase
    return s;
  endfunction

  // Inverse table, found by search over the four transitions
  function automatic logic [PAIR_W-1:0] unmapSym(input logic [MODE_W-1:0] mode,
                                                 input logic [PAIR_W-1:0] sym);
    logic [PAIR_W-1:0] res;
    res = 2'b00;
    for (int k = 0; k < 4; k++) begin
      if (mapSym(mode, 2'(k)) == sym) res = 2'(k);
    end
    return res;
  endfunction

endpackage

// File: rtl/pair_codec_ctrl.sv
module pair_codec_ctrl
  import pair_codec_pkg::*;
#(
  parameter int LANES = 4,
  localparam int CFG_W = LANES * MODE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txValid,
  input  logic             rxValid,
  input  logic [CFG_W-1:0] cfgCode,
  output strobes_t         strb,
  output logic [CFG_W-1:0] activeCode,
  output logic             symValid,
  output logic             outValid
);

  logic cfgLoad;

  always_comb begin
    strb.encStep = txValid;
    strb.decStep = rxValid;
    cfgLoad      = !txValid && !rxValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeCode <= '0;
      symValid   <= 1'b0;
      outValid   <= 1'b0;
    end else begin
      symValid <= txValid;
      outValid <= rxValid;
      if (cfgLoad) activeCode <= cfgCode;
    end
  end

endmodule

// File: rtl/pair_codec_dp.sv
module pair_codec_dp
  import pair_codec_pkg::*;
#(
  parameter int LANES = 4,
  localparam int CFG_W = LANES * MODE_W,
  localparam int BUS_W = LANES * PAIR_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strb,
  input  logic [CFG_W-1:0] activeCode,
  input  logic [BUS_W-1:0] txPair,
  input  logic [BUS_W-1:0] rxSym,
  output logic [BUS_W-1:0] symData,
  output logic [BUS_W-1:0] outPair
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [MODE_W-1:0] laneMode;
    logic [PAIR_W-1:0] newPair, prevTx, encSym, symR;
    logic [PAIR_W-1:0] inSym, prevRx, decPair;

    assign laneMode = activeCode[MODE_W*i +: MODE_W];
    assign newPair  = txPair[PAIR_W*i +: PAIR_W];
    assign inSym    = rxSym[PAIR_W*i +: PAIR_W];

    always_comb begin
      if (isCoded(laneMode)) begin
        encSym  = mapSym(laneMode, newPair ^ prevTx);
        decPair = prevRx ^ unmapSym(laneMode, inSym);
      end else begin
        encSym  = newPair;
        decPair = inSym;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prevTx <= '0;
        symR   <= '0;
        prevRx <= '0;
      end else begin
        if (strb.encStep) begin
          prevTx <= newPair;
          symR   <= encSym;
        end
        if (strb.decStep) prevRx <= decPair;
      end
    end

    assign symData[PAIR_W*i +: PAIR_W] = symR;
    assign outPair[PAIR_W*i +: PAIR_W] = prevRx;
  end

endmodule

// File: rtl/pair_codec.sv
module pair_codec
  import pair_codec_pkg::*;
#(
  parameter int LANES = 4,
  localparam int CFG_W = LANES * MODE_W,
  localparam int BUS_W = LANES * PAIR_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgCode,
  input  logic             txValid,
  input  logic [BUS_W-1:0] txPair,
  output logic             symValid,
  output logic [BUS_W-1:0] symData,
  input  logic             rxValid,
  input  logic [BUS_W-1:0] rxSym,
  output logic             outValid,
  output logic [BUS_W-1:0] outPair
);

  strobes_t         strb;
  logic [CFG_W-1:0] activeCode;

  pair_codec_ctrl #(.LANES(LANES)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .txValid    (txValid),
    .rxValid    (rxValid),
    .cfgCode    (cfgCode),
    .strb       (strb),
    .activeCode (activeCode),
    .symValid   (symValid),
    .outValid   (outValid)
  );

  pair_codec_dp #(.LANES(LANES)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .activeCode (activeCode),
    .txPair     (txPair),
    .rxSym      (rxSym),
    .symData    (symData),
    .outPair    (outPair)
  );

endmodule

// File: rtl/pair_codec_chk.sv
module pair_codec_chk
  import pair_codec_pkg::*;
#(
  parameter int LANES = 4,
  localparam int CFG_W = LANES * MODE_W,
  localparam int BUS_W = LANES * PAIR_W
) (
  input logic             clk,
  input logic             rstN,
  input logic [CFG_W-1:0] cfgCode,
  input logic             txValid,
  input logic [BUS_W-1:0] txPair,
  input logic             rxValid,
  input logic             symValid,
  input logic [BUS_W-1:0] symData,
  input logic [CFG_W-1:0] activeCode
);

  p_sym_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    txValid |=> symValid);

  p_sym_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !txValid |=> !symValid);

  p_sym_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !txValid |=> $stable(symData));

  p_cfg_freeze_r11: assert property (@(posedge clk) disable iff (!rstN)
    (txValid || rxValid) |=> $stable(activeCode));

  p_cfg_load_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!txValid && !rxValid) |=> (activeCode == $past(cfgCode)));

  p_raw_lane0_r7: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !isCoded(activeCode[MODE_W-1:0]))
      |=> (symData[PAIR_W-1:0] == $past(txPair[PAIR_W-1:0])));

endmodule

bind pair_codec pair_codec_chk #(.LANES(LANES)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgCode    (cfgCode),
  .txValid    (txValid),
  .txPair     (txPair),
  .rxValid    (rxValid),
  .symValid   (symValid),
  .symData    (symData),
  .activeCode (activeCode)
);

// File: tb/test_pair_codec.sv
module test_pair_codec;

  localparam int LANES = 4;
  localparam int CFG_W = LANES * 3;
  localparam int BUS_W = LANES * 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [CFG_W-1:0] cfgCode = '0;
  logic             txValid = 1'b0;
  logic [BUS_W-1:0] txPair = '0;
  logic             symValid;
  logic [BUS_W-1:0] symData;
  logic             rxValid;
  logic [BUS_W-1:0] rxSym;
  logic             outValid;
  logic [BUS_W-1:0] outPair;

  assign rxValid = symValid;
  assign rxSym   = symData;

  pair_codec #(.LANES(LANES)) i_pair_codec (
    .clk(clk), .rstN(rstN), .cfgCode(cfgCode),
    .txValid(txValid), .txPair(txPair),
    .symValid(symValid), .symData(symData),
    .rxValid(rxValid), .rxSym(rxSym),
    .outValid(outValid), .outPair(outPair)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  int toggles = 0;

  // Bench model state
  logic [2:0]       mActive [LANES];
  logic [1:0]       mPrevTx [LANES];
  logic [BUS_W-1:0] mSym = '0;
  logic [BUS_W-1:0] mOut = '0;
  logic             prevStepValid = 1'b0;
  logic [BUS_W-1:0] prevStepPair = '0;

  function automatic logic [1:0] expSym(input logic [2:0] m, input logic [1:0] chg);
    logic [1:0] s;
    s = chg;
    case (m)
      3'd1: s = chg;
      3'd2: case (chg) 2'b00: s = 2'b00; 2'b11: s = 2'b10; 2'b01: s = 2'b01; default: s = 2'b11; endcase
      3'd3: case (chg) 2'b00: s = 2'b01; 2'b11: s = 2'b10; 2'b01: s = 2'b00; default: s = 2'b11; endcase
      3'd4: case (chg) 2'b00: s = 2'b00; 2'b11: s = 2'b10; 2'b01: s = 2'b11; default: s = 2'b01; endcase
      default: s = chg;
    endcase
    return s;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  // One cycle: inputs applied at negedge, results sampled at the next negedge
  task automatic step(input logic v, input logic [BUS_W-1:0] p, input string tag);
    logic cfgLoadNow;
    logic [BUS_W-1:0] newSym;
    cfgLoadNow = !v && !prevStepValid;
    txValid = v;
    txPair  = p;
    newSym  = mSym;
    if (v) begin
      for (int l = 0; l < LANES; l++) begin
        logic [1:0] np;
        logic [2:0] m;
        np = p[2*l +: 2];
        m  = mActive[l];
        if (m >= 3'd1 && m <= 3'd4) newSym[2*l +: 2] = expSym(m, np ^ mPrevTx[l]);
        else                        newSym[2*l +: 2] = np;
        mPrevTx[l] = np;
      end
      toggles += $countones(newSym ^ mSym);
    end
    mSym = newSym;
    if (prevStepValid) mOut = prevStepPair;
    @(posedge clk);
    @(negedge clk);
    chk(symValid == v, "R10", "symValid", 32'(symValid), 32'(v));
    chk(symData == mSym, tag, "symData", 32'(symData), 32'(mSym));
    chk(outValid == prevStepValid, "R10", "outValid", 32'(outValid), 32'(prevStepValid));
    chk(outPair == mOut, "R9", "outPair", 32'(outPair), 32'(mOut));
    prevStepValid = v;
    prevStepPair  = p;
    if (cfgLoadNow) begin
      for (int l = 0; l < LANES; l++) mActive[l] = cfgCode[3*l +: 3];
    end
  endtask

  task automatic setAll(input logic [2:0] m);
    for (int l = 0; l < LANES; l++) cfgCode[3*l +: 3] = m;
  endtask

  task automatic idle2(input string tag);
    step(1'b0, BUS_W'($urandom), tag);
    step(1'b0, BUS_W'($urandom), tag);
  endtask

  // Every lane makes the same transition class from its current history
  task automatic sendClass(input logic [1:0] chg, input string tag);
    logic [BUS_W-1:0] p;
    for (int l = 0; l < LANES; l++) p[2*l +: 2] = mPrevTx[l] ^ chg;
    step(1'b1, p, tag);
  endtask

  initial begin
    #2000000;
    nFails++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    finishRun();
  end

  initial begin
    string tags [5];
    tags[0] = "R7"; tags[1] = "R3"; tags[2] = "R4"; tags[3] = "R5"; tags[4] = "R6";
    void'($urandom(32'd20240611));
    for (int l = 0; l < LANES; l++) begin
      mActive[l] = 3'd0;
      mPrevTx[l] = 2'b00;
    end

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(symValid == 1'b0 && outValid == 1'b0, "R1", "valids in reset", 32'({symValid, outValid}), 0);
    chk(symData == '0, "R1", "symData in reset", 32'(symData), 0);
    chk(outPair == '0, "R1", "outPair in reset", 32'(outPair), 0);
    rstN = 1'b1;

    // R1: history starts at 00, first pair 11 under mode 1 gives "both" = 11
    setAll(3'd1);
    idle2("R11");
    step(1'b1, {LANES{2'b11}}, "R1");
    step(1'b0, '0, "R1");

    // R10: an idle gap does not disturb history (same pair after idle -> no change)
    step(1'b1, {LANES{2'b10}}, "R2");
    step(1'b0, {LANES{2'b01}}, "R10");
    step(1'b1, {LANES{2'b10}}, "R10");
    idle2("R10");

    // Each mode: directed classes then random stream, with toggle count
    for (int c = 0; c <= 7; c++) begin
      string tg;
      tg = (c >= 1 && c <= 4) ? tags[c] : "R7";
      setAll(3'(c));
      idle2("R11");
      sendClass(2'b00, tg);
      sendClass(2'b11, tg);
      sendClass(2'b01, tg);
      sendClass(2'b10, tg);
      sendClass(2'b00, tg);
      toggles = 0;
      for (int k = 0; k < 200; k++) begin
        step(($urandom % 4) != 0, BUS_W'($urandom), tg);
      end
      step(1'b0, '0, tg);
      step(1'b0, '0, tg);
      $display("mode %0d: %0d symbol bit toggles over random stream", c, toggles);
    end

    // R8: mixed per-lane modes
    cfgCode = {3'd4, 3'd3, 3'd2, 3'd1};
    idle2("R11");
    sendClass(2'b11, "R8");
    sendClass(2'b01, "R8");
    sendClass(2'b10, "R8");
    for (int r = 0; r < 20; r++) begin
      cfgCode = CFG_W'($urandom);
      idle2("R11");
      for (int k = 0; k < 60; k++) step(($urandom % 3) != 0, BUS_W'($urandom), "R8");
      step(1'b0, '0, "R8");
    end

    // R11: request change while streaming has no effect until an idle pair
    setAll(3'd1);
    idle2("R11");
    sendClass(2'b00, "R11");
    setAll(3'd4);
    sendClass(2'b11, "R11");   // still mode 1: both -> 11
    sendClass(2'b01, "R11");   // still mode 1: second only -> 01
    step(1'b0, '0, "R11");     // rxValid still high, no load
    sendClass(2'b11, "R11");   // still mode 1
    idle2("R11");
    sendClass(2'b11, "R11");   // now mode 4: both -> 10
    sendClass(2'b01, "R11");   // mode 4: second only -> 11
    idle2("R9");

    finishRun();
  end

endmodule